// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block sets the timing of conversions for a two-channel converter. Both channels are sampled at the same moment and then resolved one after the other. A falling edge on the active-low start input captures both channel samples into a hold stage and raises `busy`. The sequencer then passes through a one-cycle hold phase, a channel A conversion phase and a channel B conversion phase. Each conversion phase lasts a parameterised number of cycles. A fixed-latency stand-in takes the place of the bit-decision core: the value held for a channel becomes that channel's result when its phase ends. The channel A result waits in an internal stage and does not reach its output register until channel B is done. Both output registers therefore change on the same edge, and `busy` falls on that edge too.

Two modes are available. In normal mode every conversion needs its own falling edge on the start input. In auto-repeat mode each conversion is followed by an acquisition phase with `busy` low. If the start input is still low when that phase ends, the next conversion starts without a new edge, so a start input held low keeps conversions running back to back. The result outputs stay stable and readable throughout acquisition. An active-high reset aborts any conversion, returns the block to idle and clears the results.

States: `ST_IDLE` (waiting), `ST_HOLD` (samples held, one cycle), `ST_CONV_A`, `ST_CONV_B` (one per channel, `T_CONV` cycles each) and `ST_ACQ` (auto-repeat acquisition, `T_ACQ` cycles). Transitions:
- IDLE to HOLD on a start fall.
- HOLD to CONV_A always.
- CONV_A to CONV_B on the phase's last cycle.
- CONV_B to ACQ on its last cycle in auto-repeat mode, and CONV_B to IDLE on its last cycle in normal mode.
- ACQ to HOLD at its end if the start input is low, and ACQ to IDLE at its end if the start input is high.

Top module: `conv_seq_top`

## Requirements
- R1: While `rst` is high, `busy` is 0 and `res_a`/`res_b` are 0, and any conversion in progress is abandoned. A start input that is already low when reset is released does not count as a start edge.
- R2: When idle, if `start_n` is 1 at one rising clock edge and 0 at the next, that second edge starts a conversion. `busy` is 1 after that edge, and `samp_a`/`samp_b` are captured as they stand at that edge.
- R3: Each conversion keeps `busy` high for exactly 1 + 2*T_CONV clock cycles.
- R4: `res_a` and `res_b` change only on the edge where `busy` falls. Both then take the values captured at that conversion's start, so channel A is published together with channel B and never earlier.
- R5: Falling edges of `start_n` while `busy` is high have no effect: the running conversion keeps its length and its captured samples.
- R6: In normal mode (`impulse` = 0), a `start_n` held low after a conversion never starts another conversion.
- R7: In auto-repeat mode (`impulse` = 1), `busy` stays low for exactly T_ACQ cycles after each conversion. If `start_n` is 0 at the last of those edges, a new conversion starts there, capturing the samples at that edge. Repeats continue for as long as `start_n` stays low.
- R8: In auto-repeat mode, if `start_n` is 1 when acquisition ends, the block returns to idle and no conversion starts.
- R9: During acquisition, `res_a` and `res_b` hold the last published values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset and conversion abort |
| start_n | input | 1 | Active-low start-convert; falling edge starts, low level repeats in auto-repeat mode |
| impulse | input | 1 | 1 selects auto-repeat mode, 0 selects normal mode |
| samp_a | input | W | Channel A sample value |
| samp_b | input | W | Channel B sample value |
| busy | output | 1 | High from start until both results are published |
| res_a | output | W | Channel A result register |
| res_b | output | W | Channel B result register |

## Verification
The bench builds the block with W = 12, T_CONV = 3 and T_ACQ = 2. This keeps one busy window at seven cycles and one auto-repeat period at nine cycles. The short windows let the bench land spurious start edges inside a busy window and run several back-to-back repeats in each trial. They also let it release the start input within a short acquisition and abort a conversion midway, across many random sample values.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CONV_A,
        ST_CONV_B,
        ST_ACQ
    } seq_state_t;
endpackage

// File: rtl/cs_edge_det.sv
module cs_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    output logic fall
);
    logic start_q;

    // Reset value 0: a start held low across reset release is not an edge.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= start_n;
    end

    assign fall = start_q & ~start_n;
endmodule

// File: rtl/cs_phase_cnt.sv
module cs_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cs_result_regs.sv
module cs_result_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic         done_a,
    input  logic         pub,
    input  logic [W-1:0] samp_a,
    input  logic [W-1:0] samp_b,
    output logic [W-1:0] res_a,
    output logic [W-1:0] res_b
);
    logic [W-1:0] held_a;
    logic [W-1:0] held_b;
    logic [W-1:0] conv_a;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            held_a <= '0;
            held_b <= '0;
            conv_a <= '0;
            res_a  <= '0;
            res_b  <= '0;
        end else begin
            if (cap) begin
                held_a <= samp_a;
                held_b <= samp_b;
            end
            // stand-in core: channel A result ready at end of its phase
            if (done_a) conv_a <= held_a;
            // channel A is only published once channel B is done
            if (pub) begin
                res_a <= conv_a;
                res_b <= held_b;
            end
        end
    end

    a_r4_results_only_on_publish: assert property (
        @(posedge clk) disable iff (rst)
        !pub |=> ($stable(res_a) && $stable(res_b)));
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
    import conv_seq_pkg::*;
#(
    parameter int W      = 16,
    parameter int T_CONV = 8,
    parameter int T_ACQ  = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_n,
    input  logic         impulse,
    input  logic [W-1:0] samp_a,
    input  logic [W-1:0] samp_b,
    output logic         busy,
    output logic [W-1:0] res_a,
    output logic [W-1:0] res_b
);
    localparam int MAX_T = (T_CONV > T_ACQ) ? T_CONV : T_ACQ;
    localparam int CW    = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(T_CONV - 1);
    localparam logic [CW-1:0] ACQ_LAST  = CW'(T_ACQ - 1);

    seq_state_t    state, state_nxt;
    logic          fall;
    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          last_conv, last_acq;
    logic          cap, done_a, pub;

    cs_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .fall    (fall)
    );

    cs_phase_cnt #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    cs_result_regs #(.W(W)) u_res (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .done_a (done_a),
        .pub    (pub),
        .samp_a (samp_a),
        .samp_b (samp_b),
        .res_a  (res_a),
        .res_b  (res_b)
    );

    assign last_conv = (cnt == CONV_LAST);
    assign last_acq  = (cnt == ACQ_LAST);

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (fall) state_nxt = ST_HOLD;
            ST_HOLD:   state_nxt = ST_CONV_A;
            ST_CONV_A: if (last_conv) state_nxt = ST_CONV_B;
            ST_CONV_B: if (last_conv) state_nxt = impulse ? ST_ACQ : ST_IDLE;
            ST_ACQ:    if (last_acq) state_nxt = start_n ? ST_IDLE : ST_HOLD;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        busy    = 1'b0;
        cap     = 1'b0;
        done_a  = 1'b0;
        pub     = 1'b0;
        cnt_clr = (state_nxt != state);
        unique case (state)
            ST_IDLE: begin
                cap     = fall;
                cnt_clr = 1'b1;
            end
            ST_HOLD:   busy = 1'b1;
            ST_CONV_A: begin
                busy   = 1'b1;
                done_a = last_conv;
            end
            ST_CONV_B: begin
                busy = 1'b1;
                pub  = last_conv;
            end
            ST_ACQ:    cap = last_acq & ~start_n;
            default:   cnt_clr = 1'b1;
        endcase
    end

    a_r2_fall_starts_conversion: assert property (
        @(posedge clk) disable iff (rst)
        (state == ST_IDLE && fall) |=> busy);

    a_r3_busy_ends_on_publish: assert property (
        @(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pub));

    a_r5_busy_not_cut_short: assert property (
        @(posedge clk) disable iff (rst)
        (busy && !pub) |=> busy);

    a_r6_normal_returns_idle: assert property (
        @(posedge clk) disable iff (rst)
        (pub && !impulse) |=> (state == ST_IDLE));

    a_r7_auto_restart: assert property (
        @(posedge clk) disable iff (rst)
        (state == ST_ACQ && last_acq && !start_n) |=> busy);

    a_r9_acq_quiet: assert property (
        @(posedge clk) disable iff (rst)
        (state == ST_ACQ && !last_acq) |=> (!busy && $stable(res_a) && $stable(res_b)));
endmodule

// File: tb/tb_conv_seq_top.sv
module tb_conv_seq_top;
    localparam int W      = 12;
    localparam int T_CONV = 3;
    localparam int T_ACQ  = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_n;
    logic         impulse;
    logic [W-1:0] samp_a, samp_b;
    logic         busy;
    logic [W-1:0] res_a, res_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit over   = 1'b0;

    conv_seq_top #(.W(W), .T_CONV(T_CONV), .T_ACQ(T_ACQ)) dut (
        .clk(clk), .rst(rst), .start_n(start_n), .impulse(impulse),
        .samp_a(samp_a), .samp_b(samp_b),
        .busy(busy), .res_a(res_a), .res_b(res_b)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic int f_busy_len();
        return 1 + 2 * T_CONV;
    endfunction

    function automatic int f_acq_len();
        return T_ACQ;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one normal-mode conversion, optionally with spurious start edges while busy
    task automatic run_normal(input logic [W-1:0] a, input logic [W-1:0] b, input bit glitch);
        logic [W-1:0] oa, ob;
        int n;
        impulse = 1'b0;
        @(negedge clk) start_n = 1'b1;
        @(negedge clk);
        samp_a = a; samp_b = b; start_n = 1'b0;
        oa = res_a; ob = res_b;
        @(negedge clk);
        chk("R2 busy after start fall", busy, 1);
        n = 0;
        while (busy && n < 200) begin
            n++;
            chk("R4 res_a held while busy", res_a, oa);
            chk("R4 res_b held while busy", res_b, ob);
            if (n == 1) begin samp_a = ~a; samp_b = ~b; end
            if (glitch && n == 2) start_n = 1'b1;
            if (glitch && n == 3) start_n = 1'b0;  // R5 spurious fall while busy
            @(negedge clk);
        end
        chk(glitch ? "R5 busy length with ignored edge" : "R3 busy length", n, f_busy_len());
        chk("R4 res_a published", res_a, a);
        chk("R4 res_b published", res_b, b);
        // R6: start held low, no restart
        for (int i = 0; i < 2 * T_CONV + 4; i++) begin
            chk("R6 no restart in normal mode", busy, 0);
            @(negedge clk);
        end
    endtask

    // auto-repeat run with reps conversions, releasing start during the last acquisition
    task automatic run_impulse(input int reps);
        logic [W-1:0] a, b, ea, eb;
        int n, m;
        impulse = 1'b1;
        @(negedge clk) start_n = 1'b1;
        @(negedge clk);
        a = W'($urandom); b = W'($urandom);
        samp_a = a; samp_b = b; start_n = 1'b0;
        @(negedge clk);
        chk("R2 busy after start fall (auto mode)", busy, 1);
        for (int r = 0; r < reps; r++) begin
            n = 0;
            while (busy && n < 200) begin
                n++;
                if (n == 1) begin samp_a = ~a; samp_b = ~b; end
                @(negedge clk);
            end
            chk("R3 busy length (auto mode)", n, f_busy_len());
            chk("R4 res_a published (auto mode)", res_a, a);
            chk("R4 res_b published (auto mode)", res_b, b);
            ea = a; eb = b;
            a = W'($urandom); b = W'($urandom);
            samp_a = a; samp_b = b;
            if (r < reps - 1) begin
                m = 0;
                while (!busy && m < 50) begin
                    m++;
                    chk("R9 res_a stable in acquisition", res_a, ea);
                    chk("R9 res_b stable in acquisition", res_b, eb);
                    @(negedge clk);
                end
                chk("R7 acquisition length then restart", m, f_acq_len());
            end else begin
                start_n = 1'b1;
                for (int i = 0; i < T_ACQ + 6; i++) begin
                    chk("R8 no conversion after release", busy, 0);
                    chk("R9 res_a stable after last", res_a, ea);
                    @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!over) begin
            over = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_n = 1'b1; impulse = 1'b0; samp_a = '0; samp_b = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 res_a in reset", res_a, 0);
        chk("R1 res_b in reset", res_b, 0);
        rst = 1'b0;
        @(negedge clk);

        // directed corners
        run_normal('0, {W{1'b1}}, 1'b0);
        run_normal({W{1'b1}}, '0, 1'b1);
        run_impulse(4);

        // reset aborts a running conversion (R1)
        run_normal(12'h5A5, 12'h3C3, 1'b0);
        @(negedge clk) start_n = 1'b1;
        @(negedge clk) samp_a = 12'h111; samp_b = 12'h222; start_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy mid conversion before abort", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 busy after abort", busy, 0);
        chk("R1 res_a cleared", res_a, 0);
        chk("R1 res_b cleared", res_b, 0);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R1 low start at release is no edge", busy, 0);
        end

        // random trials
        for (int t = 0; t < 25; t++) begin
            if ($urandom_range(0, 2) == 0)
                run_impulse($urandom_range(1, 4));
            else
                run_normal(W'($urandom), W'($urandom), 1'($urandom_range(0, 1)));
        end

        if (!over) begin
            over = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule